// File: doc/BRIEF.md
# Read Data Output Stage with Selectable Register and Matched Deselect Timing

This block sits between the read port of a synchronous memory array and the data pins. It takes the array's read word and sends it to the output either directly (flow-through) or through one rising-edge output register (pipelined). A single mode input picks the path. A read command that is sampled on one clock edge makes the array present its word during the following cycle.

The block also tracks whether the outputs should be driven. A read command sets an internal "active" flag and a deselect command clears it. That flag passes through the same number of stages as the data, so a deselect reaches the drivers exactly when a read issued on the same edge would have delivered its data. In pipelined mode this means the outputs keep driving for one more full cycle after the deselect edge and turn off just after the second rising edge. The final drive enable is gated by an output-enable input that acts asynchronously.

Top module: `rdp_read_path`

## Requirements
- R1: In pipelined mode (`pipe_mode`=1), `rd_data` shows the `arr_rdata` word of the previous cycle whenever that previous cycle followed a sampled read or continue with the active flag set. Otherwise `rd_data` holds its last value.
- R2: In flow-through mode (`pipe_mode`=0), `rd_data` follows `arr_rdata` combinationally within the same cycle.
- R3: At each rising edge the active flag is set by `rd_req`=1 and cleared by `desel_req`=1. Deselect wins when both are high. It holds when neither is high, so a burst continues.
- R4: In pipelined mode `drv_en` follows the active flag delayed by one more edge. After a deselect edge the outputs drive for one full further cycle and switch off just after the second rising edge.
- R5: In flow-through mode `drv_en` follows the active flag directly. Outputs drive in the cycle after a read edge and switch off in the cycle after a deselect edge.
- R6: `drv_en` is the active state of the selected stage ANDed with `oe_async`. A change of `oe_async` reaches `drv_en` without a clock edge.
- R7: While `rst_n`=0 at a rising edge, both active stages and the output register clear, so `drv_en`=0 and pipelined `rd_data`=0.
- R8: A read issued on the edge right after a deselect edge delivers data with no bubble other than the single deselected beat.
- R9: The first data of a read appears one cycle later in pipelined mode than in flow-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through |
| rd_req | input | 1 | Read command, sampled at rising edge |
| desel_req | input | 1 | Deselect command, sampled at rising edge |
| arr_rdata | input | DATA_W | Array read word for the current cycle |
| oe_async | input | 1 | Asynchronous output enable, active high |
| rd_data | output | DATA_W | Data toward the pins |
| drv_en | output | 1 | Output-driver enable |

## Verification
The assertions assume that `pipe_mode` changes only while reset is held and that the command inputs are stable, two-state values around each rising edge. The data check in pipelined mode also assumes `arr_rdata` is stable at the edge. The bench changes the mode only with `rst_n` low and changes every input at the falling edge. It moves `oe_async` mid-cycle only to probe the asynchronous gating, well away from the rising edge.

// File: rtl/rdp_pkg.sv
// Package for the read output stage: shared sizes and the command decode.
// Assumes: at most one command class is taken per edge, with deselect first.
package rdp_pkg;

    localparam int unsigned RDP_DATA_W_DEF = 36;
    localparam int unsigned RDP_ACT_STAGES = 2;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_DESEL = 2'd2
    } rdp_cmd_e;

    // Map raw request lines to one command, deselect taking priority.
    function automatic rdp_cmd_e rdp_decode(input logic rd, input logic ds);
        if (ds)      return CMD_DESEL;
        else if (rd) return CMD_READ;
        else         return CMD_HOLD;
    endfunction

endpackage

// File: rtl/rdp_act_pipe.sv
// Active-flag pipeline: stage 0 holds the selection state set by reads and
// cleared by deselects; later stages delay it by one edge each so it
// tracks the data path depth.
// Assumes: synchronous active-low reset, commands stable at the edge.
module rdp_act_pipe
    import rdp_pkg::*;
#(
    parameter int unsigned STAGES = RDP_ACT_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rdp_cmd_e          cmd,
    output logic [STAGES-1:0] act
);

    logic [STAGES-1:0] act_q;

    // Stage 0: update the selection state from the decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q[0] <= 1'b0;
        end else begin
            case (cmd)
                CMD_READ:  act_q[0] <= 1'b1;
                CMD_DESEL: act_q[0] <= 1'b0;
                default:   act_q[0] <= act_q[0];
            endcase
        end
    end

    // Later stages: shift the state one edge per stage.
    for (genvar g = 1; g < STAGES; g++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) act_q[g] <= 1'b0;
            else        act_q[g] <= act_q[g-1];
        end
    end

    assign act = act_q;

    AST_RD_SET:   assert property (@(posedge clk) disable iff (!rst_n)
                      (cmd == CMD_READ) |=> act[0]);                  // R3
    AST_DS_CLR:   assert property (@(posedge clk) disable iff (!rst_n)
                      (cmd == CMD_DESEL) |=> !act[0]);                // R3
    AST_HOLD_ACT: assert property (@(posedge clk) disable iff (!rst_n)
                      (cmd == CMD_HOLD) |=> $stable(act[0]));         // R3

endmodule

// File: rtl/rdp_data_reg.sv
// Output data register: captures the array word on a rising edge whenever
// the current cycle carries valid read data, and otherwise keeps its value.
// Assumes: synchronous active-low reset; din settles before the edge.
module rdp_data_reg #(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Capture valid read data, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (cap_en) dout <= din;
    end

endmodule

// File: rtl/rdp_read_path.sv
// Read output stage top: selects flow-through or pipelined data and the
// matching stage of the active pipeline, then gates the drive enable with
// the asynchronous output enable.
// Assumes: pipe_mode changes only while reset is held.
module rdp_read_path
    import rdp_pkg::*;
#(
    parameter int unsigned DATA_W = RDP_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              rd_req,
    input  logic              desel_req,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              oe_async,
    output logic [DATA_W-1:0] rd_data,
    output logic              drv_en
);

    localparam int unsigned NSTG = RDP_ACT_STAGES;

    rdp_cmd_e          cmd;
    logic [NSTG-1:0]   act;
    logic [DATA_W-1:0] reg_data;
    logic              sel_act;

    // Decode the raw request lines.
    always_comb cmd = rdp_decode(rd_req, desel_req);

    rdp_act_pipe #(.STAGES(NSTG)) i_act (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .act   (act)
    );

    rdp_data_reg #(.DATA_W(DATA_W)) i_dreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (act[0]),
        .din    (arr_rdata),
        .dout   (reg_data)
    );

    // Pick data path and drive stage by mode.
    always_comb begin
        if (pipe_mode) begin
            rd_data = reg_data;
            sel_act = act[NSTG-1];
        end else begin
            rd_data = arr_rdata;
            sel_act = act[0];
        end
    end

    // Asynchronous output-enable gate on the drivers.
    assign drv_en = sel_act & oe_async;

    AST_PIPE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                       (pipe_mode && act[0]) |=> (rd_data == $past(arr_rdata))); // R1
    AST_DCD_OFF:   assert property (@(posedge clk) disable iff (!rst_n)
                       (pipe_mode && desel_req) |=> ##1 !drv_en);      // R4
    AST_FT_ON:     assert property (@(posedge clk) disable iff (!rst_n)
                       (!pipe_mode && rd_req && !desel_req) |=> (drv_en || !oe_async)); // R5
    AST_RST_OFF:   assert property (@(posedge clk)
                       !rst_n |=> !drv_en);                            // R7

endmodule

// File: tb/test_rdp_read_path.sv
module test_rdp_read_path;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NV = 15;
    // {rd, ds, oe, arr[7:0], exp_data[7:0], exp_en}
    localparam logic [19:0] VEC [0:NV-1] = '{
        {1'b1,1'b0,1'b1,8'hA0,8'h00,1'b0},
        {1'b1,1'b0,1'b1,8'hA1,8'h00,1'b0},
        {1'b0,1'b1,1'b1,8'hA2,8'hA1,1'b1},
        {1'b0,1'b0,1'b1,8'hA3,8'hA2,1'b1},
        {1'b1,1'b0,1'b1,8'hA4,8'hA2,1'b0},
        {1'b0,1'b0,1'b1,8'hA5,8'hA2,1'b0},
        {1'b0,1'b0,1'b0,8'hA6,8'hA5,1'b0},
        {1'b0,1'b0,1'b1,8'hA7,8'hA6,1'b1},
        {1'b0,1'b1,1'b1,8'hA8,8'hA7,1'b1},
        {1'b1,1'b0,1'b1,8'hA9,8'hA8,1'b1},
        {1'b0,1'b0,1'b1,8'hAA,8'hA8,1'b0},
        {1'b0,1'b0,1'b1,8'hAB,8'hAA,1'b1},
        {1'b1,1'b1,1'b1,8'hAC,8'hAB,1'b1},
        {1'b0,1'b0,1'b1,8'hAD,8'hAC,1'b1},
        {1'b0,1'b0,1'b1,8'hAE,8'hAC,1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          rd_req = 1'b0;
    logic          desel_req = 1'b0;
    logic [DW-1:0] arr_rdata = '0;
    logic          oe_async = 1'b1;
    logic [DW-1:0] rd_data;
    logic          drv_en;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdp_read_path #(.DATA_W(DW)) i_rdp_read_path (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .rd_req(rd_req),
        .desel_req(desel_req), .arr_rdata(arr_rdata), .oe_async(oe_async),
        .rd_data(rd_data), .drv_en(drv_en)
    );

    task automatic chk(input string tag, input logic [DW-1:0] exp_d, input logic exp_e);
        total++;
        if (rd_data !== exp_d || drv_en !== exp_e) begin
            bad++;
            $display("FAIL %s: rd_data=%h drv_en=%b expected rd_data=%h drv_en=%b",
                     tag, rd_data, drv_en, exp_d, exp_e);
        end
    endtask

    task automatic chk_en(input string tag, input logic exp_e);
        total++;
        if (drv_en !== exp_e) begin
            bad++;
            $display("FAIL %s: drv_en=%b expected %b", tag, drv_en, exp_e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD*2000);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        // R7: reset state in pipelined mode
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1 chk("R7 reset", 8'h00, 1'b0);

        // Vector table, pipelined mode (R1 R3 R4 R6 R8 R9)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rst_n     = 1'b1;
            rd_req    = VEC[i][19];
            desel_req = VEC[i][18];
            oe_async  = VEC[i][17];
            arr_rdata = VEC[i][16:9];
            #1 chk($sformatf("R1/R4 pipelined row %0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R6: asynchronous gating in the middle of a driving cycle
        @(negedge clk);
        rd_req = 1'b1; desel_req = 1'b0; oe_async = 1'b1;
        repeat (2) @(negedge clk);
        rd_req = 1'b0;
        #1 chk_en("R6 pipelined drive before gate", 1'b1);
        oe_async = 1'b0;
        #1 chk_en("R6 gate off without clock", 1'b0);
        oe_async = 1'b1;
        #1 chk_en("R6 gate on without clock", 1'b1);

        // Switch to flow-through under reset
        @(negedge clk);
        rst_n = 1'b0; pipe_mode = 1'b0; rd_req = 1'b0; desel_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        arr_rdata = 8'h11;
        #1 chk("R7 reset flow-through", 8'h11, 1'b0);

        // R5/R9: read on next edge, data in the very next cycle
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        arr_rdata = 8'h5A;
        #1 chk("R9 flow-through first data", 8'h5A, 1'b1);
        // R2: combinational bypass
        arr_rdata = 8'h3C;
        #1 chk("R2 bypass follows array", 8'h3C, 1'b1);
        desel_req = 1'b1;
        @(negedge clk);
        desel_req = 1'b0;
        arr_rdata = 8'h77;
        #1 chk("R5 flow-through off one cycle after deselect", 8'h77, 1'b0);
        // R8 in flow-through: read right after deselect
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        arr_rdata = 8'h99;
        #1 chk("R8 flow-through read after deselect", 8'h99, 1'b1);
        // R3: hold keeps driving
        @(negedge clk);
        arr_rdata = 8'h9A;
        #1 chk("R3 hold continues burst", 8'h9A, 1'b1);

        finish_run();
    end

endmodule